// File: doc/BRIEF.md
# Transmit Tap Weight Combiner

This block computes, once per unit interval, a signed number that stands for the total output current of a multi-tap serial transmitter. Twelve data bits arrive in each cycle. One is the current bit (the main tap). Three are the same stream delayed by one, two and three UI (pre-emphasis taps). Eight are the stream after a programmable round-trip delay, at one-UI steps after that delay (reflection taps). Each tap has a 6-bit strength and an inversion flag. A tap adds its strength when its effective bit is one and subtracts it when the bit is zero. The twelve signed terms are summed and registered.

All tap settings and a 4-bit line-termination code are loaded serially through a configuration scan chain. Bits shift into a shadow register while shift enable is high. A capture strobe then copies the whole shadow register into the active register. Because of this, the weights in use never change partway through a load. The active termination code is brought out as a port for the termination network.

Top module: `txtap_combiner`

## Requirements
- R1: After synchronous reset, `sum_out`, `term_code` and `scan_out` are 0, and every active tap strength is 0. With any data, the sum therefore stays 0 until the first capture.
- R2: In a cycle with `scan_en` high, the 88-bit shadow register shifts up by one place and `scan_in` enters at bit 0. `scan_out` always shows shadow bit 87. With `scan_en` low, the shadow register holds, so `scan_out` is unchanged.
- R3: Shadow and active register layout: bits [3:0] hold the termination code. Tap k (k = 0..11) owns bits [4+7k+5 : 4+7k] as its unsigned strength and bit 4+7k+6 as its inversion flag.
- R4: A cycle with `scan_capture` high copies the shadow register as it was before that edge into the active register. Shifting without a capture changes neither `term_code` nor the sum produced for given data.
- R5: Tap k contributes +strength when (data bit XOR inversion flag) is 1 and -strength otherwise. Setting the inversion flag therefore negates that tap's contribution.
- R6: `sum_out` equals the sum of all twelve contributions, using the data present at a clock edge and the active register at that edge. It appears one cycle after that edge.
- R7: `sum_out` is 11-bit two's complement and reaches +756 and -756 (twelve taps at strength 63) without wrapping.
- R8: Tap order: index 0 is `main_bit`, indices 1..3 are `pre_bits[0..2]` (1, 2, 3 UI delay), and indices 4..11 are `refl_bits[0..7]` (base delay plus 0..7 UI).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UI clock |
| rst | input | 1 | synchronous active-high reset |
| main_bit | input | 1 | current data bit (tap 0) |
| pre_bits | input | 3 | pre-emphasis delayed bits (taps 1..3) |
| refl_bits | input | 8 | reflection-path delayed bits (taps 4..11) |
| scan_en | input | 1 | shift enable for the configuration chain |
| scan_in | input | 1 | serial configuration data |
| scan_capture | input | 1 | copy shadow register to active register |
| scan_out | output | 1 | last bit of the shadow register |
| sum_out | output | 11 | registered signed tap sum |
| term_code | output | 4 | active termination code |

## Verification
Random data words are applied under several random configurations. Mismatches there expose errors in tap order, field position or sign. All-ones and all-zeros data at full strength reach the two extremes of the sum range, which shows any wrap-around. A small-strength configuration with one inverted tap separates inversion handling from the data sign. A load that is shifted but never captured shows whether the weights leak into use before capture.

// File: rtl/txtap_pkg.sv
package txtap_pkg;
    localparam int NUM_PRE   = 3;
    localparam int NUM_REFL  = 8;
    localparam int NUM_TAPS  = 1 + NUM_PRE + NUM_REFL;
    localparam int MAG_W     = 6;
    localparam int TERM_W    = 4;
    localparam int FIELD_W   = MAG_W + 1;
    localparam int CHAIN_LEN = NUM_TAPS * FIELD_W + TERM_W;
    localparam int MAX_ABS   = NUM_TAPS * ((1 << MAG_W) - 1);
    localparam int SUM_W     = $clog2(MAX_ABS + 1) + 1;

    typedef struct packed {
        logic             invert;
        logic [MAG_W-1:0] mag;
    } tap_cfg_t;

    typedef logic signed [SUM_W-1:0] sum_t;

    // signed contribution of one tap
    function automatic sum_t tap_term(input logic bit_in, input tap_cfg_t cfg);
        sum_t m;
        m = sum_t'(cfg.mag);
        return (bit_in ^ cfg.invert) ? m : -m;
    endfunction
endpackage

// File: rtl/txtap_scan_cfg.sv
module txtap_scan_cfg #(
    parameter int LEN = 88
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           shift_in,
    input  logic           capture,
    output logic           shift_out,
    output logic [LEN-1:0] active_q
);
    logic [LEN-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (shift_en) begin
            shadow_q <= {shadow_q[LEN-2:0], shift_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
        end else if (capture) begin
            active_q <= shadow_q;
        end
    end

    assign shift_out = shadow_q[LEN-1];
endmodule

// File: rtl/txtap_cfg_unpack.sv
module txtap_cfg_unpack
    import txtap_pkg::*;
#(
    parameter int TAPS  = NUM_TAPS,
    parameter int TW    = TERM_W,
    parameter int LEN   = TAPS * FIELD_W + TW
) (
    input  logic [LEN-1:0] vec_i,
    output tap_cfg_t       taps_o [TAPS],
    output logic [TW-1:0]  term_o
);
    assign term_o = vec_i[TW-1:0];

    for (genvar k = 0; k < TAPS; k++) begin : g_field
        localparam int BASE = TW + k * FIELD_W;
        assign taps_o[k].mag    = vec_i[BASE +: MAG_W];
        assign taps_o[k].invert = vec_i[BASE + MAG_W];
    end
endmodule

// File: rtl/txtap_adder.sv
module txtap_adder
    import txtap_pkg::*;
#(
    parameter int TAPS = NUM_TAPS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TAPS-1:0] bits_i,
    input  tap_cfg_t        taps_i [TAPS],
    output sum_t            sum_q
);
    sum_t terms [TAPS];
    sum_t acc;

    for (genvar k = 0; k < TAPS; k++) begin : g_term
        assign terms[k] = tap_term(bits_i[k], taps_i[k]);
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + terms[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else begin
            sum_q <= acc;
        end
    end
endmodule

// File: rtl/txtap_combiner.sv
module txtap_combiner
    import txtap_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    main_bit,
    input  logic [NUM_PRE-1:0]      pre_bits,
    input  logic [NUM_REFL-1:0]     refl_bits,
    input  logic                    scan_en,
    input  logic                    scan_in,
    input  logic                    scan_capture,
    output logic                    scan_out,
    output logic signed [SUM_W-1:0] sum_out,
    output logic [TERM_W-1:0]       term_code
);
    logic [CHAIN_LEN-1:0] active_vec;
    tap_cfg_t             taps [NUM_TAPS];
    logic [NUM_TAPS-1:0]  tap_bits;
    sum_t                 sum_q;

    assign tap_bits = {refl_bits, pre_bits, main_bit};

    txtap_scan_cfg #(.LEN(CHAIN_LEN)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (scan_en),
        .shift_in  (scan_in),
        .capture   (scan_capture),
        .shift_out (scan_out),
        .active_q  (active_vec)
    );

    txtap_cfg_unpack #(.TAPS(NUM_TAPS), .TW(TERM_W), .LEN(CHAIN_LEN)) u_unpack (
        .vec_i  (active_vec),
        .taps_o (taps),
        .term_o (term_code)
    );

    txtap_adder #(.TAPS(NUM_TAPS)) u_add (
        .clk    (clk),
        .rst    (rst),
        .bits_i (tap_bits),
        .taps_i (taps),
        .sum_q  (sum_q)
    );

    assign sum_out = sum_q;
endmodule

// File: rtl/txtap_combiner_chk.sv
module txtap_combiner_chk
    import txtap_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    main_bit,
    input logic [NUM_PRE-1:0]      pre_bits,
    input logic [NUM_REFL-1:0]     refl_bits,
    input logic                    scan_en,
    input logic                    scan_capture,
    input logic                    scan_out,
    input logic signed [SUM_W-1:0] sum_out,
    input logic [TERM_W-1:0]       term_code
);
    logic [NUM_TAPS-1:0] bits_all;
    assign bits_all = {refl_bits, pre_bits, main_bit};

    // R4
    term_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_capture |=> $stable(term_code));

    // R2
    scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(scan_out));

    // R7
    sum_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sum_out <= SUM_W'(MAX_ABS)) && (sum_out >= -SUM_W'(MAX_ABS)));

    // R6
    sum_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(bits_all) && !$past(scan_capture)) |=> $stable(sum_out));
endmodule

bind txtap_combiner txtap_combiner_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .main_bit     (main_bit),
    .pre_bits     (pre_bits),
    .refl_bits    (refl_bits),
    .scan_en      (scan_en),
    .scan_capture (scan_capture),
    .scan_out     (scan_out),
    .sum_out      (sum_out),
    .term_code    (term_code)
);

// File: tb/txtap_combiner_tb.sv
module txtap_combiner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEN = 88;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        main_bit = 1'b0;
    logic [2:0]  pre_bits = '0;
    logic [7:0]  refl_bits = '0;
    logic        scan_en = 1'b0;
    logic        scan_in = 1'b0;
    logic        scan_capture = 1'b0;
    logic        scan_out;
    logic signed [10:0] sum_out;
    logic [3:0]  term_code;

    int checks = 0;
    int fails  = 0;
    logic [LEN-1:0] act_vec = '0;
    logic [LEN-1:0] sh_vec  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txtap_combiner u_dut (
        .clk(clk), .rst(rst), .main_bit(main_bit), .pre_bits(pre_bits),
        .refl_bits(refl_bits), .scan_en(scan_en), .scan_in(scan_in),
        .scan_capture(scan_capture), .scan_out(scan_out),
        .sum_out(sum_out), .term_code(term_code)
    );

    function automatic int exp_sum(input logic [11:0] d, input logic [LEN-1:0] v);
        int s = 0;
        for (int k = 0; k < 12; k++) begin
            int m = int'(v[4 + 7*k +: 6]);
            logic p = v[4 + 7*k + 6];
            s += (d[k] ^ p) ? m : -m;
        end
        return s;
    endfunction

    function automatic logic [LEN-1:0] make_cfg(input int mag, input logic [11:0] inv, input logic [3:0] tc);
        logic [LEN-1:0] v = '0;
        v[3:0] = tc;
        for (int k = 0; k < 12; k++) begin
            v[4 + 7*k +: 6] = 6'(mag);
            v[4 + 7*k + 6] = inv[k];
        end
        return v;
    endfunction

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_chain(input logic [LEN-1:0] v);
        for (int i = LEN-1; i >= 0; i--) begin
            @(negedge clk);
            scan_en = 1'b1;
            scan_in = v[i];
            @(posedge clk);
        end
        @(negedge clk);
        scan_en = 1'b0;
        sh_vec = v;
    endtask

    task automatic do_capture();
        @(negedge clk);
        scan_capture = 1'b1;
        @(posedge clk);
        @(negedge clk);
        scan_capture = 1'b0;
        act_vec = sh_vec;
    endtask

    task automatic apply(input logic [11:0] d, input string req);
        @(negedge clk);
        main_bit  = d[0];
        pre_bits  = d[3:1];
        refl_bits = d[11:4];
        @(posedge clk);
        @(negedge clk);
        check_int(req, int'(sum_out), exp_sum(d, act_vec));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [LEN-1:0] v;
        int seed;
        seed = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_int("R1 sum", int'(sum_out), 0);
        check_int("R1 term", int'(term_code), 0);
        check_int("R1 scan_out", int'(scan_out), 0);
        apply(12'hFFF, "R1 zero weights");

        // R7 full strength extremes, R5 all-ones vs all-zeros
        load_chain(make_cfg(63, 12'h000, 4'hA));
        // R2 first shifted bit now at the top of the chain
        check_int("R2 scan_out", int'(scan_out), int'(sh_vec[LEN-1]));
        do_capture();
        // R4 captured termination code
        check_int("R4 term", int'(term_code), 10);
        apply(12'hFFF, "R7 max");
        check_int("R7 max value", int'(sum_out), 756);
        apply(12'h000, "R7 min");
        check_int("R7 min value", int'(sum_out), -756);

        // R5 inversion: strength 1, main inverted, data zeros -> +1 - 11 = -10
        load_chain(make_cfg(1, 12'h001, 4'h3));
        // R4 shifted but not captured: old weights and code remain
        check_int("R4 term no capture", int'(term_code), 10);
        apply(12'hFFF, "R4 old weights");
        do_capture();
        apply(12'h000, "R5 inverted main");
        check_int("R5 value", int'(sum_out), -10);

        // R8 single-tap probes with distinct strengths
        v = '0;
        for (int k = 0; k < 12; k++) v[4 + 7*k +: 6] = 6'(k + 1);
        load_chain(v);
        do_capture();
        for (int k = 0; k < 12; k++) begin
            apply(12'(1 << k), "R8 tap order");
        end

        // R2 hold: scan_en low keeps scan_out
        @(negedge clk);
        scan_in = ~scan_out;
        @(posedge clk);
        @(negedge clk);
        check_int("R2 hold", int'(scan_out), int'(sh_vec[LEN-1]));

        // R3 R6 random configurations and data
        for (int c = 0; c < 6; c++) begin
            v = {$urandom, $urandom, $urandom};
            load_chain(v);
            do_capture();
            check_int("R3 term field", int'(term_code), int'(v[3:0]));
            for (int n = 0; n < 40; n++) begin
                apply(12'($urandom), "R6 random sum");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule